// File: doc/BRIEF.md
# Local Bus Cycle Claim Sequencer

This block sits on a 486-style host bus and decides, for every cycle started by the CPU, a local-bus master or a DMA/ISA master, whether the bridge keeps it. It claims each new cycle speculatively by pulling its local-device output low one clock after the address strobe. It then samples the local-device and local-memory indications together with an address-decoder verdict, at a point chosen by a strap that is held during reset.

Cycles that belong to local memory or to a local-bus slave are left to their owner. The claim is held until that owner's last ready. Cycles routed to the bridge start a transaction on the downstream engine through a request/done/abort handshake; the handshake is already synchronised.

When the downstream side answers with master-abort, or the decoder finds no owner at all, the block terminates the host cycle with back-off and local ready. It then refuses to claim the CPU's rerun of that cycle, so the rerun falls through to the slow expansion bus.

Top module: `lbc_claim_seq`

## Requirements
- R1: While reset is held low, `ldev_out_n`, `lrdy_n` and `boff_n` are 1, and `dn_req_o` and `retry_err_o` are 0.
- R2: A strobe (`ads_n` = 0) sampled in the idle state, and not marked for skipping, drives `ldev_out_n` to 0 from that same clock edge onward.
- R3: The strap level present at the last clock edge of reset selects the sampling edge. A 1 selects the edge that ends the first T2 (one edge after the strobe edge). A 0 selects the end of the second T2 (two edges after the strobe edge). `late_sample_o` is 1 for the second-T2 choice and keeps its value after reset.
- R4: At the sampling edge, the cycle is classified by priority: local memory (`lmem_n` = 0) first, then local slave (`ldev_in_n` = 0). Either one starts no downstream request. `ldev_out_n` stays 0 until the edge that samples `last_rdy_n` = 0, and is 1 after that edge.
- R5: With `cfg_quiet_lmem` = 1, a cycle classified as local memory releases `ldev_out_n` to 1 at the sampling edge. The block still waits for `last_rdy_n` before it accepts a new strobe.
- R6: A cycle that is neither local nor rejected (`dec_pci_i` = 1) raises `dn_req_o` at the sampling edge and holds it until `dn_done_i` is sampled 1. After that edge `lrdy_n` is 0 for one cycle, `ldev_out_n` is 1 and `dn_req_o` is 0.
- R7: A downstream abort (`dn_abort_i` = 1 while requesting), or a non-local cycle with `dec_pci_i` = 0 at the sampling edge, starts the back-off sequence. `boff_n` is 0 for one cycle starting at that edge, `lrdy_n` is 0 for one cycle after the configured delay, and `ldev_out_n` returns to 1 one edge after the ready cycle.
- R8: The ready delay field `cfg_rdy_dly` maps 2'b00 to 0 clocks, 2'b01 to 1 clock, and 2'b10 or 2'b11 to 2 clocks, counted from the back-off edge.
- R9: After a back-off, the next strobe is not claimed: `ldev_out_n` stays 1. The strobe after that one is claimed again.
- R10: With `cfg_boff_off` = 1, an abort leaves `boff_n` at 1 and still returns `lrdy_n` with the configured delay. It sets `retry_err_o`, which stays 1 until reset. The next strobe is claimed normally.
- R11: A strobe that arrives while a cycle is in progress has no effect on the outputs or on the sequence of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_strap_i | input | 1 | Sampling-point strap, captured while reset is low |
| ads_n | input | 1 | Address strobe, active low |
| ldev_in_n | input | 1 | Combined local-slave claim, active low |
| lmem_n | input | 1 | Local-memory indication, active low |
| dec_pci_i | input | 1 | Decoder verdict: cycle may go downstream |
| last_rdy_n | input | 1 | Last ready of a locally owned cycle, active low |
| cfg_quiet_lmem | input | 1 | Release the claim at the sampling edge on local-memory cycles |
| cfg_boff_off | input | 1 | Disable back-off on abort |
| cfg_rdy_dly | input | 2 | Ready delay after back-off |
| dn_req_o | output | 1 | Downstream transaction request |
| dn_done_i | input | 1 | Downstream transaction completed |
| dn_abort_i | input | 1 | Downstream transaction ended in master-abort |
| ldev_out_n | output | 1 | Local-device claim, active low |
| lrdy_n | output | 1 | Local ready, active low |
| boff_n | output | 1 | Back-off, active low |
| late_sample_o | output | 1 | 1 when the second-T2 sampling point is in use |
| retry_err_o | output | 1 | Sticky flag: abort seen while back-off was disabled |

## Verification
The bench builds the block with its default parameters: a two-bit ready-delay field whose delay saturates at two clocks. All four field codes are therefore reachable, including the saturating 2'b11. It runs one reset with the strap high and one with the strap low. On the late-sampling runs, it drives deliberately wrong decode inputs at the first-T2 edge, so that sampling at the wrong edge changes the visible outcome.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

    localparam int RDY_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T2A,
        ST_T2B,
        ST_LOCAL,
        ST_DOWN,
        ST_ABT,
        ST_REL
    } lbc_state_e;

    typedef enum logic [1:0] {
        CL_NONE,
        CL_LMEM,
        CL_LSLV,
        CL_PCI
    } lbc_class_e;

    typedef struct packed {
        lbc_state_e       st;
        logic             ldev_n;
        logic             lrdy_n;
        logic             boff_n;
        logic             req;
        logic             skip;
        logic             err;
        logic [RDY_W-1:0] cnt;
    } lbc_regs_t;

    localparam lbc_regs_t LBC_RST = '{
        st:     ST_IDLE,
        ldev_n: 1'b1,
        lrdy_n: 1'b1,
        boff_n: 1'b1,
        req:    1'b0,
        skip:   1'b0,
        err:    1'b0,
        cnt:    '0
    };

endpackage

// File: rtl/lbc_strap.sv
module lbc_strap (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_i,
    output logic late_o
);
    logic late_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            late_q <= !strap_i;
        end
    end

    assign late_o = late_q;

    // R3: the captured choice never moves once reset has been released
    a_r3_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(late_q));

endmodule

// File: rtl/lbc_classify.sv
module lbc_classify
    import lbc_pkg::*;
(
    input  logic       ldev_in_n,
    input  logic       lmem_n,
    input  logic       dec_pci_i,
    output lbc_class_e cls_o
);
    always_comb begin
        if (!lmem_n) begin
            cls_o = CL_LMEM;
        end else if (!ldev_in_n) begin
            cls_o = CL_LSLV;
        end else if (dec_pci_i) begin
            cls_o = CL_PCI;
        end else begin
            cls_o = CL_NONE;
        end
    end
endmodule

// File: rtl/lbc_rdy_delay.sv
module lbc_rdy_delay #(
    parameter int W   = 2,
    parameter int MAX = 2
) (
    input  logic [W-1:0] field_i,
    output logic [W-1:0] cycles_o
);
    localparam logic [W-1:0] MAXV = W'(MAX);

    assign cycles_o = (field_i > MAXV) ? MAXV : field_i;
endmodule

// File: rtl/lbc_claim_seq.sv
module lbc_claim_seq
    import lbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_strap_i,
    input  logic             ads_n,
    input  logic             ldev_in_n,
    input  logic             lmem_n,
    input  logic             dec_pci_i,
    input  logic             last_rdy_n,
    input  logic             cfg_quiet_lmem,
    input  logic             cfg_boff_off,
    input  logic [RDY_W-1:0] cfg_rdy_dly,
    output logic             dn_req_o,
    input  logic             dn_done_i,
    input  logic             dn_abort_i,
    output logic             ldev_out_n,
    output logic             lrdy_n,
    output logic             boff_n,
    output logic             late_sample_o,
    output logic             retry_err_o
);
    lbc_regs_t        r_q;
    lbc_regs_t        r_d;
    logic             late;
    lbc_class_e       cls;
    logic [RDY_W-1:0] dly;
    logic             sample_now;
    logic             abort_now;

    lbc_strap u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap_i (smp_strap_i),
        .late_o  (late)
    );

    lbc_classify u_cls (
        .ldev_in_n (ldev_in_n),
        .lmem_n    (lmem_n),
        .dec_pci_i (dec_pci_i),
        .cls_o     (cls)
    );

    lbc_rdy_delay #(.W(RDY_W), .MAX(2)) u_dly (
        .field_i  (cfg_rdy_dly),
        .cycles_o (dly)
    );

    always_comb begin
        r_d        = r_q;
        r_d.lrdy_n = 1'b1;
        r_d.boff_n = 1'b1;
        abort_now  = 1'b0;
        sample_now = (r_q.st == ST_T2B) || (r_q.st == ST_T2A && !late);

        case (r_q.st)
            ST_IDLE: begin
                if (!ads_n) begin
                    if (r_q.skip) begin
                        r_d.skip = 1'b0;
                    end else begin
                        r_d.st     = ST_T2A;
                        r_d.ldev_n = 1'b0;
                    end
                end
            end
            ST_T2A, ST_T2B: begin
                if (!sample_now) begin
                    r_d.st = ST_T2B;
                end else begin
                    case (cls)
                        CL_LMEM: begin
                            r_d.st = ST_LOCAL;
                            if (cfg_quiet_lmem) begin
                                r_d.ldev_n = 1'b1;
                            end
                        end
                        CL_LSLV: r_d.st = ST_LOCAL;
                        CL_PCI: begin
                            r_d.st  = ST_DOWN;
                            r_d.req = 1'b1;
                        end
                        default: abort_now = 1'b1;
                    endcase
                end
            end
            ST_LOCAL: begin
                if (!last_rdy_n) begin
                    r_d.ldev_n = 1'b1;
                    r_d.st     = ST_IDLE;
                end
            end
            ST_DOWN: begin
                if (dn_abort_i) begin
                    r_d.req   = 1'b0;
                    abort_now = 1'b1;
                end else if (dn_done_i) begin
                    r_d.req    = 1'b0;
                    r_d.lrdy_n = 1'b0;
                    r_d.ldev_n = 1'b1;
                    r_d.st     = ST_IDLE;
                end
            end
            ST_ABT: begin
                r_d.cnt = r_q.cnt - 1'b1;
                if (r_q.cnt == RDY_W'(1)) begin
                    r_d.lrdy_n = 1'b0;
                    r_d.st     = ST_REL;
                end
            end
            ST_REL: begin
                r_d.ldev_n = 1'b1;
                r_d.skip   = !cfg_boff_off;
                r_d.st     = ST_IDLE;
            end
            default: r_d = LBC_RST;
        endcase

        if (abort_now) begin
            if (cfg_boff_off) begin
                r_d.err = 1'b1;
            end else begin
                r_d.boff_n = 1'b0;
            end
            if (dly == '0) begin
                r_d.lrdy_n = 1'b0;
                r_d.st     = ST_REL;
            end else begin
                r_d.cnt = dly;
                r_d.st  = ST_ABT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= LBC_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign dn_req_o      = r_q.req;
    assign ldev_out_n    = r_q.ldev_n;
    assign lrdy_n        = r_q.lrdy_n;
    assign boff_n        = r_q.boff_n;
    assign late_sample_o = late;
    assign retry_err_o   = r_q.err;

    // R2: an unmarked strobe in idle is claimed on the next edge
    a_r2_claim_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !ads_n && !r_q.skip) |=> !ldev_out_n);

    // R9: a marked strobe is left unclaimed
    a_r9_rerun_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !ads_n && r_q.skip) |=> ldev_out_n);

    // R4: a locally owned cycle never requests downstream
    a_r4_local_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOCAL) |-> !dn_req_o);

    // R6: the claim is held for as long as a downstream request is open
    a_r6_req_keeps_claim: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_o |-> !ldev_out_n);

    // R6: ready is a single-cycle pulse
    a_r6_rdy_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !lrdy_n |=> lrdy_n);

    // R7: back-off is a single-cycle pulse
    a_r7_boff_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !boff_n |=> boff_n);

    // R10: the error flag is sticky
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        retry_err_o |=> retry_err_o);

endmodule

// File: tb/lbc_claim_seq_tb.sv
module lbc_claim_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_strap_i = 1'b1;
    logic       ads_n = 1'b1;
    logic       ldev_in_n = 1'b1;
    logic       lmem_n = 1'b1;
    logic       dec_pci_i = 1'b0;
    logic       last_rdy_n = 1'b1;
    logic       cfg_quiet_lmem = 1'b0;
    logic       cfg_boff_off = 1'b0;
    logic [1:0] cfg_rdy_dly = 2'b00;
    logic       dn_done_i = 1'b0;
    logic       dn_abort_i = 1'b0;
    logic       dn_req_o;
    logic       ldev_out_n;
    logic       lrdy_n;
    logic       boff_n;
    logic       late_sample_o;
    logic       retry_err_o;

    int checks = 0;
    int fails  = 0;
    logic err_seen = 1'b0;
    logic done_flag = 1'b0;

    always #10 clk = ~clk;

    lbc_claim_seq dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .smp_strap_i    (smp_strap_i),
        .ads_n          (ads_n),
        .ldev_in_n      (ldev_in_n),
        .lmem_n         (lmem_n),
        .dec_pci_i      (dec_pci_i),
        .last_rdy_n     (last_rdy_n),
        .cfg_quiet_lmem (cfg_quiet_lmem),
        .cfg_boff_off   (cfg_boff_off),
        .cfg_rdy_dly    (cfg_rdy_dly),
        .dn_req_o       (dn_req_o),
        .dn_done_i      (dn_done_i),
        .dn_abort_i     (dn_abort_i),
        .ldev_out_n     (ldev_out_n),
        .lrdy_n         (lrdy_n),
        .boff_n         (boff_n),
        .late_sample_o  (late_sample_o),
        .retry_err_o    (retry_err_o)
    );

    // kind: 0 local slave, 1 local memory, 2 downstream done, 3 downstream abort, 4 no owner
    // fields: kind[10:8] dly[7:6] boff_off[5] quiet[4] latency[3:2] expected_ready_delay[1:0]
    localparam int NV = 12;
    localparam logic [10:0] VEC [NV] = '{
        {3'd0, 2'b00, 1'b0, 1'b0, 2'd1, 2'd0},
        {3'd1, 2'b00, 1'b0, 1'b0, 2'd0, 2'd0},
        {3'd1, 2'b00, 1'b0, 1'b1, 2'd2, 2'd0},
        {3'd2, 2'b00, 1'b0, 1'b0, 2'd0, 2'd0},
        {3'd2, 2'b00, 1'b0, 1'b0, 2'd3, 2'd0},
        {3'd3, 2'b00, 1'b0, 1'b0, 2'd1, 2'd0},
        {3'd3, 2'b01, 1'b0, 1'b0, 2'd0, 2'd1},
        {3'd3, 2'b10, 1'b0, 1'b0, 2'd2, 2'd2},
        {3'd3, 2'b11, 1'b0, 1'b0, 2'd0, 2'd2},
        {3'd4, 2'b00, 1'b0, 1'b0, 2'd0, 2'd0},
        {3'd3, 2'b01, 1'b1, 1'b0, 2'd1, 2'd1},
        {3'd2, 2'b00, 1'b0, 1'b0, 2'd1, 2'd0}
    };

    task automatic tick;
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic strap);
        rst_n       = 1'b0;
        smp_strap_i = strap;
        repeat (3) tick();
        chk(ldev_out_n == 1'b1, "R1 ldev_out_n", ldev_out_n, 1);
        chk(lrdy_n == 1'b1, "R1 lrdy_n", lrdy_n, 1);
        chk(boff_n == 1'b1, "R1 boff_n", boff_n, 1);
        chk(dn_req_o == 1'b0, "R1 dn_req_o", dn_req_o, 0);
        chk(retry_err_o == 1'b0, "R1 retry_err_o", retry_err_o, 0);
        rst_n       = 1'b1;
        smp_strap_i = !strap;
        err_seen    = 1'b0;
        tick();
        chk(late_sample_o == !strap, "R3 late_sample_o", late_sample_o, !strap);
    endtask

    task automatic drive_class(input int kind);
        case (kind)
            0: begin ldev_in_n = 1'b0; lmem_n = 1'b1; dec_pci_i = 1'b0; end
            1: begin ldev_in_n = 1'b1; lmem_n = 1'b0; dec_pci_i = 1'b1; end
            2, 3: begin ldev_in_n = 1'b1; lmem_n = 1'b1; dec_pci_i = 1'b1; end
            default: begin ldev_in_n = 1'b1; lmem_n = 1'b1; dec_pci_i = 1'b0; end
        endcase
    endtask

    task automatic abort_tail(input logic dis, input int expdly);
        if (dis) err_seen = 1'b1;
        chk(boff_n == dis, "R7 boff_n at abort edge", boff_n, dis);
        chk(lrdy_n == (expdly != 0), "R8 lrdy_n at abort edge", lrdy_n, expdly != 0);
        chk(ldev_out_n == 1'b0, "R7 claim held at abort edge", ldev_out_n, 0);
        for (int i = 1; i <= expdly; i++) begin
            tick();
            chk(boff_n == 1'b1, "R7 boff_n single cycle", boff_n, 1);
            chk(lrdy_n == (i != expdly), "R8 delayed lrdy_n", lrdy_n, i != expdly);
        end
        tick();
        chk(ldev_out_n == 1'b1, "R7 claim dropped after ready", ldev_out_n, 1);
        chk(lrdy_n == 1'b1, "R7 lrdy_n single cycle", lrdy_n, 1);
        chk(retry_err_o == err_seen, "R10 retry_err_o", retry_err_o, err_seen);
        if (!dis) begin
            ads_n = 1'b0;
            tick();
            ads_n = 1'b1;
            chk(ldev_out_n == 1'b1, "R9 rerun not claimed", ldev_out_n, 1);
            tick();
            chk(ldev_out_n == 1'b1, "R9 rerun stays unclaimed", ldev_out_n, 1);
        end
    endtask

    task automatic run_vec(input logic [10:0] v, input logic late);
        int kind;
        int lat;
        int expdly;
        logic quiet;
        logic dis;
        logic exp_ldev;
        kind   = int'(v[10:8]);
        lat    = int'(v[3:2]);
        expdly = int'(v[1:0]);
        quiet  = v[4];
        dis    = v[5];
        cfg_rdy_dly    = v[7:6];
        cfg_boff_off   = dis;
        cfg_quiet_lmem = quiet;

        ads_n = 1'b0;
        tick();
        ads_n = 1'b1;
        chk(ldev_out_n == 1'b0, "R2 claim after strobe", ldev_out_n, 0);

        if (late) begin
            // wrong-edge inputs: opposite classification
            if (kind <= 1) drive_class(2);
            else           drive_class(0);
            tick();
            chk(dn_req_o == 1'b0, "R3 no decision at first T2", dn_req_o, 0);
            chk(boff_n == 1'b1, "R3 no back-off at first T2", boff_n, 1);
        end
        drive_class(kind);
        tick();
        drive_class(4);

        if (kind <= 1) begin
            exp_ldev = (kind == 1) && quiet;
            chk(dn_req_o == 1'b0, "R4 no downstream request", dn_req_o, 0);
            chk(ldev_out_n == exp_ldev, "R5 claim level local", ldev_out_n, exp_ldev);
            ads_n = 1'b0;
            tick();
            ads_n = 1'b1;
            chk(ldev_out_n == exp_ldev, "R11 strobe mid-cycle ignored", ldev_out_n, exp_ldev);
            chk(dn_req_o == 1'b0, "R11 no request from mid-cycle strobe", dn_req_o, 0);
            for (int i = 0; i < lat; i++) begin
                tick();
                chk(ldev_out_n == exp_ldev, "R4 claim held until last ready", ldev_out_n, exp_ldev);
            end
            last_rdy_n = 1'b0;
            tick();
            last_rdy_n = 1'b1;
            chk(ldev_out_n == 1'b1, "R4 claim released", ldev_out_n, 1);
            chk(lrdy_n == 1'b1, "R4 no local ready", lrdy_n, 1);
        end else if (kind == 2) begin
            chk(dn_req_o == 1'b1, "R6 request raised", dn_req_o, 1);
            for (int i = 0; i < lat; i++) begin
                tick();
                chk(dn_req_o == 1'b1 && ldev_out_n == 1'b0, "R6 request held", dn_req_o, 1);
            end
            dn_done_i = 1'b1;
            tick();
            dn_done_i = 1'b0;
            chk(lrdy_n == 1'b0, "R6 ready on done", lrdy_n, 0);
            chk(ldev_out_n == 1'b1, "R6 claim released on done", ldev_out_n, 1);
            chk(dn_req_o == 1'b0, "R6 request dropped", dn_req_o, 0);
            tick();
            chk(lrdy_n == 1'b1, "R6 ready single cycle", lrdy_n, 1);
        end else if (kind == 3) begin
            chk(dn_req_o == 1'b1, "R7 request before abort", dn_req_o, 1);
            for (int i = 0; i < lat; i++) tick();
            dn_abort_i = 1'b1;
            tick();
            dn_abort_i = 1'b0;
            chk(dn_req_o == 1'b0, "R7 request dropped on abort", dn_req_o, 0);
            abort_tail(dis, expdly);
        end else begin
            chk(dn_req_o == 1'b0, "R7 no request without owner", dn_req_o, 0);
            abort_tail(dis, expdly);
        end
        cfg_boff_off = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        if (!done_flag) begin
            $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        for (int k = 0; k < NV; k++) begin
            run_vec(VEC[k], 1'b0);
        end
        chk(retry_err_o == 1'b1, "R10 flag still set", retry_err_o, 1);

        do_reset(1'b0);
        chk(retry_err_o == 1'b0, "R10 flag cleared by reset", retry_err_o, 0);
        run_vec({3'd0, 2'b00, 1'b0, 1'b0, 2'd1, 2'd0}, 1'b1);
        run_vec({3'd2, 2'b00, 1'b0, 1'b0, 2'd2, 2'd0}, 1'b1);
        run_vec({3'd1, 2'b00, 1'b0, 1'b1, 2'd0, 2'd0}, 1'b1);
        run_vec({3'd4, 2'b10, 1'b0, 1'b0, 2'd0, 2'd2}, 1'b1);
        run_vec({3'd4, 2'b00, 1'b1, 1'b0, 2'd0, 2'd0}, 1'b1);
        run_vec({3'd2, 2'b00, 1'b0, 1'b0, 2'd0, 2'd0}, 1'b1);

        done_flag = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule